// File: doc/BRIEF.md
# Per-Channel Interrupt Status Aggregator

This block collects interrupt events for a multi-channel DMA engine and folds them into a single interrupt line. Each channel has a sticky six-bit status word, an enable word and a write-one-to-clear port. The datapath raises status bits with single-cycle event pulses. A channel's summary bit is the OR of its status bits that are also enabled. The engine keeps its own two-bit error status with the same set, clear and enable scheme.

The channel summaries and the engine summary are gathered into one 32-bit source word. The top bit is the engine and the low bits are the channels, one bit each. A separate source mask selects which of these bits may drive the interrupt. Software sets a channel's mask bit when it brings the channel up and clears it when it tears the channel down. To service an interrupt, software reads a status word and writes the same value back to the matching clear address.

All registers are reached through a simple register bus. Reads return data one cycle after the request. Byte address map:

- 0x000: source word (read-only, before the mask)
- 0x004: source mask
- 0x008: engine status
- 0x00C: engine clear
- 0x010: engine enable
- 0x100 + 16·c + {0, 4, 8}: status, clear and enable of channel c

Top module: `chan_irq_aggr`

## Requirements
- R1: After reset, every status, enable and mask bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: An event pulse on `ch_evt[6*c+k]` sets bit k of channel c's status, whether or not that bit is enabled. The bit positions are: 0 processed descriptor, 1 inactivity timer, 2 wake, 3 out of descriptors, 4 error, 5 end of transfer. Status reads back at 0x100+16·c.
- R3: A write to a channel's clear address (status address + 4) clears exactly the status bits written as 1 and leaves all other bits unchanged.
- R4: If an event pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R5: Source-word bit c is the OR of channel c's status ANDed with its enable (enable at status address + 8). The source word at 0x000 reads without the mask applied.
- R6: `eng_evt[1]` sets engine status bit 2 (error) and `eng_evt[0]` sets engine status bit 1 (bus-response error). Engine clear at 0x00C and engine enable at 0x010 use the same positions. Source-word bit 31 is the OR of the enabled engine status bits.
- R7: `irq` is the OR of (source word AND mask), registered, so it changes one clock after the state that causes it. Only mask bits 31 and [NUM_CH-1:0] are stored; all other mask bits read as 0.
- R8: `bus_rdata` is loaded on the clock edge where `bus_rd_en` is high and holds its value otherwise. Unmapped addresses read as 0, and writes to them change no state. Unmapped addresses are global offsets 0x014–0x0FF, offset 12 within a channel block, and channels ≥ NUM_CH.
- R9: Writes to the source word, engine status or channel status addresses have no effect, and clear addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ch_evt | input | NUM_CH*6 | Per-channel event pulses, six per channel |
| eng_evt | input | 2 | Engine event pulses: [0] bus-response error, [1] error |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with NUM_CH = 5, which is not a power of two. This makes channel 5's address block (0x150) fall just past the last real channel, so the bench can check that an out-of-range channel decode is rejected. With five channels, the mask readback (0x8000001F) also shows exactly which mask bits are stored. The default ADDR_W of 12 is kept, so the channel region sits above the global region with spare decode space on both sides.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

  localparam int DATA_W         = 32;
  localparam int CH_EVT_W       = 6;
  localparam int ENG_EVT_W      = 2;
  localparam int ENG_LSB        = 1;
  localparam int ENG_SRC_BIT    = 31;
  localparam int CH_IDX_W       = 5;
  localparam int MAX_CH         = 31;
  localparam int CH_REGION_BASE = 'h100;
  localparam int CH_STRIDE_LG   = 4;
  localparam int GLB_REGION_SZ  = 'h20;

  typedef enum logic [2:0] {
    G_SOURCE     = 3'd0,
    G_MASK       = 3'd1,
    G_ENG_STATUS = 3'd2,
    G_ENG_CLEAR  = 3'd3,
    G_ENG_ENABLE = 3'd4
  } glb_reg_e;

  typedef enum logic [1:0] {
    C_STATUS = 2'd0,
    C_CLEAR  = 2'd1,
    C_ENABLE = 2'd2
  } chan_reg_e;

  typedef struct packed {
    logic                glb_hit;
    glb_reg_e            glb;
    logic                ch_hit;
    logic [CH_IDX_W-1:0] ch;
    chan_reg_e           creg;
  } reg_sel_t;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import chan_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);

  localparam int IDX_W = ADDR_W - CH_STRIDE_LG;

  logic [ADDR_W-1:0] ch_off;
  logic [IDX_W-1:0]  ch_idx;
  logic              in_glb;
  logic              in_ch;
  logic              unused_off;

  assign unused_off = ^ch_off[1:0];

  always_comb begin
    ch_off = addr - ADDR_W'(CH_REGION_BASE);
    ch_idx = ch_off[ADDR_W-1:CH_STRIDE_LG];
    in_glb = (addr < ADDR_W'(GLB_REGION_SZ));
    in_ch  = (addr >= ADDR_W'(CH_REGION_BASE)) && (ch_idx < IDX_W'(NUM_CH));
    sel    = '0;
    if (in_glb && (addr[4:2] <= 3'd4)) begin
      sel.glb_hit = 1'b1;
      sel.glb     = glb_reg_e'(addr[4:2]);
    end
    if (in_ch && (ch_off[3:2] != 2'd3)) begin
      sel.ch_hit = 1'b1;
      sel.ch     = CH_IDX_W'(ch_idx);
      sel.creg   = chan_reg_e'(ch_off[3:2]);
    end
  end

endmodule

// File: rtl/irq_src_slice.sv
module irq_src_slice #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_mask,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] enable,
  output logic         summary
);

  logic [W-1:0] status_d;
  logic         status_ce;

  // event wins over clear on the same bit
  always_comb begin
    status_d  = (status & ~clr_mask) | evt;
    status_ce = (|evt) | (|clr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (status_ce) begin
      status <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (en_we) begin
      enable <= en_wdata;
    end
  end

  assign summary = |(status & enable);

endmodule

// File: rtl/chan_irq_aggr.sv
module chan_irq_aggr
  import chan_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_CH*CH_EVT_W-1:0] ch_evt,
  input  logic [ENG_EVT_W-1:0]       eng_evt,
  output logic                       irq
);

  localparam int FLAT_W = NUM_CH * CH_EVT_W;

  initial begin
    if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range");
    if (ADDR_W < 10) $error("ADDR_W too small");
  end

  reg_sel_t sel;

  logic [FLAT_W-1:0]    ch_status_flat;
  logic [FLAT_W-1:0]    ch_enable_flat;
  logic [FLAT_W-1:0]    ch_clr_flat;
  logic [NUM_CH-1:0]    ch_sum;
  logic [ENG_EVT_W-1:0] eng_status;
  logic [ENG_EVT_W-1:0] eng_enable;
  logic [ENG_EVT_W-1:0] eng_clr;
  logic                 eng_sum;
  logic                 eng_en_we;

  logic [NUM_CH-1:0]    mask_ch_q,  mask_ch_d;
  logic                 mask_eng_q, mask_eng_d;
  logic                 mask_we;

  logic [DATA_W-1:0]    src_word;
  logic [DATA_W-1:0]    mask_word;
  logic                 irq_d;
  logic [DATA_W-1:0]    rdata_d;
  logic                 unused_wdata;

  assign unused_wdata = ^bus_wdata;

  irq_addr_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  // ---------------- per-channel slices ----------------
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic this_ch;
    logic clr_we;
    logic en_we;

    assign this_ch = bus_wr_en && sel.ch_hit && (sel.ch == CH_IDX_W'(c));
    assign clr_we  = this_ch && (sel.creg == C_CLEAR);
    assign en_we   = this_ch && (sel.creg == C_ENABLE);
    assign ch_clr_flat[c*CH_EVT_W +: CH_EVT_W] =
      clr_we ? bus_wdata[CH_EVT_W-1:0] : '0;

    irq_src_slice #(
      .W (CH_EVT_W)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (ch_evt[c*CH_EVT_W +: CH_EVT_W]),
      .clr_mask (ch_clr_flat[c*CH_EVT_W +: CH_EVT_W]),
      .en_we    (en_we),
      .en_wdata (bus_wdata[CH_EVT_W-1:0]),
      .status   (ch_status_flat[c*CH_EVT_W +: CH_EVT_W]),
      .enable   (ch_enable_flat[c*CH_EVT_W +: CH_EVT_W]),
      .summary  (ch_sum[c])
    );
  end

  // ---------------- engine slice ----------------
  assign eng_clr   = (bus_wr_en && sel.glb_hit && (sel.glb == G_ENG_CLEAR)) ?
                     bus_wdata[ENG_LSB +: ENG_EVT_W] : '0;
  assign eng_en_we = bus_wr_en && sel.glb_hit && (sel.glb == G_ENG_ENABLE);

  irq_src_slice #(
    .W (ENG_EVT_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (eng_evt),
    .clr_mask (eng_clr),
    .en_we    (eng_en_we),
    .en_wdata (bus_wdata[ENG_LSB +: ENG_EVT_W]),
    .status   (eng_status),
    .enable   (eng_enable),
    .summary  (eng_sum)
  );

  // ---------------- source mask ----------------
  always_comb begin
    mask_we    = bus_wr_en && sel.glb_hit && (sel.glb == G_MASK);
    mask_ch_d  = bus_wdata[NUM_CH-1:0];
    mask_eng_d = bus_wdata[ENG_SRC_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_ch_q  <= '0;
      mask_eng_q <= 1'b0;
    end else if (mask_we) begin
      mask_ch_q  <= mask_ch_d;
      mask_eng_q <= mask_eng_d;
    end
  end

  // ---------------- global word and output ----------------
  always_comb begin
    src_word               = '0;
    src_word[NUM_CH-1:0]   = ch_sum;
    src_word[ENG_SRC_BIT]  = eng_sum;
    mask_word              = '0;
    mask_word[NUM_CH-1:0]  = mask_ch_q;
    mask_word[ENG_SRC_BIT] = mask_eng_q;
    irq_d                  = |(src_word & mask_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rdata_d = '0;
    if (sel.glb_hit) begin
      case (sel.glb)
        G_SOURCE:     rdata_d = src_word;
        G_MASK:       rdata_d = mask_word;
        G_ENG_STATUS: rdata_d[ENG_LSB +: ENG_EVT_W] = eng_status;
        G_ENG_ENABLE: rdata_d[ENG_LSB +: ENG_EVT_W] = eng_enable;
        default:      rdata_d = '0;
      endcase
    end else if (sel.ch_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel.ch == CH_IDX_W'(c)) begin
          case (sel.creg)
            C_STATUS: rdata_d[CH_EVT_W-1:0] = ch_status_flat[c*CH_EVT_W +: CH_EVT_W];
            C_ENABLE: rdata_d[CH_EVT_W-1:0] = ch_enable_flat[c*CH_EVT_W +: CH_EVT_W];
            default:  rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      bus_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_aggr_checker.sv
module irq_aggr_checker #(
  parameter int NUM_CH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CH*6-1:0]   ch_evt,
  input logic [NUM_CH*6-1:0]   ch_clr,
  input logic [NUM_CH*6-1:0]   ch_status,
  input logic [1:0]            eng_evt,
  input logic [1:0]            eng_status,
  input logic [31:0]           src_word,
  input logic [31:0]           mask_word,
  input logic                  irq
);

  for (genvar i = 0; i < NUM_CH*6; i++) begin : g_bit
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_evt[i] |=> ch_status[i]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_status[i] && !ch_evt[i]) |=> !ch_status[i]);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_status[i] && !ch_clr[i]) |=> ch_status[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_clr[i] && !ch_evt[i]) |=> !ch_status[i]);
    p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_clr[i] && ch_evt[i]) |=> ch_status[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_eng
    p_eng_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_evt[j] |=> eng_status[j]);
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(src_word & mask_word)));

endmodule

bind chan_irq_aggr irq_aggr_checker #(
  .NUM_CH (NUM_CH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_evt     (ch_evt),
  .ch_clr     (ch_clr_flat),
  .ch_status  (ch_status_flat),
  .eng_evt    (eng_evt),
  .eng_status (eng_status),
  .src_word   (src_word),
  .mask_word  (mask_word),
  .irq        (irq)
);

// File: tb/chan_irq_aggr_bench.sv
`timescale 1ns/100ps
module chan_irq_aggr_bench;

  localparam int NCH    = 5;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_SRC  = 12'h000;
  localparam logic [ADDR_W-1:0] A_MASK = 12'h004;
  localparam logic [ADDR_W-1:0] A_EST  = 12'h008;
  localparam logic [ADDR_W-1:0] A_ECLR = 12'h00C;
  localparam logic [ADDR_W-1:0] A_EEN  = 12'h010;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr_en = 1'b0;
  logic              bus_rd_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH*6-1:0]  ch_evt = '0;
  logic [1:0]        eng_evt = '0;
  logic              irq;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  chan_irq_aggr #(
    .NUM_CH (NCH),
    .ADDR_W (ADDR_W)
  ) u_chan_irq_aggr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_evt    (ch_evt),
    .eng_evt   (eng_evt),
    .irq       (irq)
  );

  function automatic logic [ADDR_W-1:0] ch_addr(int c, int r);
    return ADDR_W'(32'h100 + c * 16 + r * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_check(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse_ch(int c, logic [5:0] bits);
    @(negedge clk);
    ch_evt[c*6 +: 6] = bits;
    @(negedge clk);
    ch_evt = '0;
  endtask

  task automatic pulse_eng(logic [1:0] bits);
    @(negedge clk);
    eng_evt = bits;
    @(negedge clk);
    eng_evt = '0;
  endtask

  task automatic t_reset();
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd_check("R1 source", A_SRC, 32'h0);
    rd_check("R1 mask", A_MASK, 32'h0);
    rd_check("R1 ch0 status", ch_addr(0, 0), 32'h0);
    rd_check("R1 ch4 enable", ch_addr(4, 2), 32'h0);
    rd_check("R1 eng status", A_EST, 32'h0);
  endtask

  task automatic t_events();
    pulse_ch(2, 6'h08);
    rd_check("R2 ch2 out-of-desc bit3", ch_addr(2, 0), 32'h08);
    pulse_ch(4, 6'h20);
    rd_check("R2 ch4 end-of-transfer bit5", ch_addr(4, 0), 32'h20);
    pulse_ch(2, 6'h01);
    rd_check("R2 ch2 accumulates bit0", ch_addr(2, 0), 32'h09);
    rd_check("R5 no summary while disabled", A_SRC, 32'h0);
    check("R7 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    pulse_ch(1, 6'h3F);
    rd_check("R2 ch1 all six", ch_addr(1, 0), 32'h3F);
    wr(ch_addr(1, 1), 32'h05);
    rd_check("R3 partial clear", ch_addr(1, 0), 32'h3A);
    wr(ch_addr(1, 0), 32'hFFFF_FFFF);
    rd_check("R9 status write ignored", ch_addr(1, 0), 32'h3A);
    rd_check("R9 clear reads zero", ch_addr(1, 1), 32'h0);
    rd_check("R2 ch2 untouched by ch1 clear", ch_addr(2, 0), 32'h09);
  endtask

  task automatic t_collide();
    @(negedge clk);
    ch_evt[1*6 + 1] = 1'b1;
    bus_wr_en = 1'b1; bus_addr = ch_addr(1, 1); bus_wdata = 32'h12;
    @(negedge clk);
    ch_evt = '0; bus_wr_en = 1'b0;
    rd_check("R4 event beats clear", ch_addr(1, 0), 32'h2A);
  endtask

  task automatic t_summary();
    wr(ch_addr(1, 2), 32'h01);
    rd_check("R5 enable readback", ch_addr(1, 2), 32'h01);
    rd_check("R5 enabled bit not set", A_SRC, 32'h0);
    wr(ch_addr(1, 2), 32'h08);
    rd_check("R5 ch1 summary", A_SRC, 32'h02);
    wr(A_MASK, 32'h02);
    check("R7 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq rises", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h04);
    @(negedge clk);
    check("R7 other mask bit", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h02);
    @(negedge clk);
    check("R7 irq again", {31'b0, irq}, 32'h1);
    wr(ch_addr(1, 1), 32'h08);
    @(negedge clk);
    check("R7 irq drops after clear", {31'b0, irq}, 32'h0);
    rd_check("R5 summary gone", A_SRC, 32'h0);
  endtask

  task automatic t_engine();
    pulse_eng(2'b10);
    rd_check("R6 error bit2", A_EST, 32'h4);
    pulse_eng(2'b01);
    rd_check("R6 bus-resp bit1", A_EST, 32'h6);
    rd_check("R6 engine disabled", A_SRC, 32'h0);
    wr(A_EEN, 32'h2);
    rd_check("R6 engine enable readback", A_EEN, 32'h2);
    rd_check("R6 source bit31", A_SRC, 32'h8000_0000);
    wr(A_MASK, 32'h8000_0000);
    @(negedge clk);
    check("R7 engine irq", {31'b0, irq}, 32'h1);
    wr(A_ECLR, 32'h2);
    rd_check("R6 engine clear", A_EST, 32'h4);
    check("R7 engine irq low", {31'b0, irq}, 32'h0);
    wr(A_EST, 32'hFFFF_FFFF);
    rd_check("R9 engine status write ignored", A_EST, 32'h4);
    wr(A_MASK, 32'hFFFF_FFFF);
    rd_check("R7 mask stored bits", A_MASK, 32'h8000_001F);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h020, 32'hFFFF_FFFF);
    wr(ch_addr(5, 2), 32'h3F);
    wr(ch_addr(0, 3), 32'h3F);
    rd_check("R8 beyond last channel", ch_addr(5, 2), 32'h0);
    rd_check("R8 global hole", 12'h020, 32'h0);
    rd_check("R8 ch0 enable untouched", ch_addr(0, 2), 32'h0);
    rd_check("R8 ch4 enable untouched", ch_addr(4, 2), 32'h0);
    rd_check("R8 source unchanged", A_SRC, 32'h0);
    rd(ch_addr(2, 0), v);
    check("R8 read ch2", v, 32'h09);
    @(negedge clk);
    @(negedge clk);
    check("R8 rdata holds", bus_rdata, 32'h09);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_clear();
    t_collide();
    t_summary();
    t_engine();
    t_unmapped();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule